// File: doc/BRIEF.md
# Serial Bus CRC-8 Frame Checker

This block folds a 64-bit identity frame into an 8-bit check register one bit at a time, in the order the bits come off a single-wire bus: least significant bit first. The frame holds a 56-bit payload (an 8-bit type code plus a 48-bit serial field), followed by an 8-bit check byte. The check polynomial is x^8 + x^5 + x^4 + 1. It is applied in reflected form, so the register shifts right and uses the constant 0x8C. When the whole frame, check byte included, has been fed in, a correct frame leaves the register at zero.

A bus master places the block beside its bit receiver. It pulses `bit_vld` with each received bit, reads `done` after the last bit, and then reads `crc_ok`. The `clr` input starts a new frame. A small state machine tracks the frame:

- `S_EMPTY`: no bit accepted yet.
- `S_ACCUM`: some bits accepted.
- `S_FULL`: all 64 bits accepted.

The transitions are:

- `S_EMPTY` to `S_ACCUM` on the first accepted bit.
- `S_ACCUM` to `S_FULL` on the 64th bit.
- Any state to `S_EMPTY` on `clr`.

Top module: `onew_crc_top`

## Requirements
- R1: After reset or a clear, `crc_out` is 0x00, and `done` and `crc_ok` are 0.
- R2: Each accepted bit updates the register in three steps: fb = crc[0] XOR bit; the register shifts right by one; if fb is 1, the result is XORed with 0x8C. Bits are taken least significant first.
- R3: A cycle with `bit_vld` low leaves `crc_out` and `done` unchanged.
- R4: `done` rises in the cycle after the 64th accepted bit, and not before. After 63 bits it is still 0.
- R5: `crc_ok` is 1 exactly when `done` is 1 and `crc_out` is 0x00. This holds exactly when the last byte equals the CRC of the first 56 bits. While `done` is 0, `crc_ok` is 0, even if the register holds zero.
- R6: Once `done` is 1, further bits are ignored: `crc_out` and `done` hold until a clear.
- R7: `clr` zeroes the register and the bit count in the same cycle. It takes priority over a simultaneous `bit_vld`.
- R8: After the 56 payload bits, `crc_out` equals the CRC of the payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear; starts a new frame |
| bit_vld | input | 1 | `bit_in` carries a received bit this cycle |
| bit_in | input | 1 | Received bus bit, least significant first |
| crc_out | output | 8 | Running CRC register |
| done | output | 1 | All 64 frame bits accepted |
| crc_ok | output | 1 | Frame passes the check (meaningful while `done` is 1) |

## Verification
The bench feeds an all-zero frame and stops it one bit short. A design that tested only for a zero residue would report a pass after 63 bits, and a design that miscounted would raise `done` one bit early or late. It sends extra bits after the frame is full, and it asserts `clr` together with `bit_vld`, to catch a design that keeps shifting, or that lets the bit win over the clear. Frames with a single corrupted bit in the check byte must fail. Bits separated by idle cycles must give the same result as back-to-back bits, which exposes a register that shifts without a valid bit.

// File: rtl/onew_crc_pkg.sv
package onew_crc_pkg;
    localparam int unsigned CRC_W      = 8;
    localparam logic [7:0]  POLY_REFL  = 8'h8C;
    localparam int unsigned FRAME_BITS = 64;

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_ACCUM = 2'd1,
        S_FULL  = 2'd2
    } frame_state_e;
endpackage

// File: rtl/onew_crc_engine.sv
module onew_crc_engine #(
    parameter int unsigned          W    = 8,
    parameter logic [W-1:0]         POLY = 8'h8C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] crc
);
    logic         fb;
    logic [W-1:0] crc_nxt;

    assign fb = crc[0] ^ din;

    // Right shift with reflected polynomial taps.
    genvar gi;
    generate
        for (gi = 0; gi < W - 1; gi++) begin : g_tap
            assign crc_nxt[gi] = crc[gi+1] ^ (fb & POLY[gi]);
        end
    endgenerate
    assign crc_nxt[W-1] = fb & POLY[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        crc <= '0;
        else if (clr)      crc <= '0;
        else if (shift_en) crc <= crc_nxt;
    end
endmodule

// File: rtl/onew_bit_ctr.sv
module onew_bit_ctr #(
    parameter int unsigned FRAME_BITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last_bit
);
    localparam int unsigned CW = $clog2(FRAME_BITS + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_BITS - 1);

    logic [CW-1:0] cnt;

    assign last_bit = (cnt == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/onew_crc_top.sv
module onew_crc_top
    import onew_crc_pkg::*;
#(
    parameter int unsigned          W          = CRC_W,
    parameter logic [W-1:0]         POLY       = POLY_REFL,
    parameter int unsigned          NBITS      = FRAME_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         bit_vld,
    input  logic         bit_in,
    output logic [W-1:0] crc_out,
    output logic         done,
    output logic         crc_ok
);
    frame_state_e st_q, st_d;
    logic         accept;
    logic         last_bit;

    assign accept = bit_vld && !clr && (st_q != S_FULL);

    onew_crc_engine #(.W(W), .POLY(POLY)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .shift_en (accept),
        .din      (bit_in),
        .crc      (crc_out)
    );

    onew_bit_ctr #(.FRAME_BITS(NBITS)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .inc      (accept),
        .last_bit (last_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_EMPTY: if (accept) st_d = last_bit ? S_FULL : S_ACCUM;
            S_ACCUM: if (accept && last_bit) st_d = S_FULL;
            S_FULL:  st_d = S_FULL;
            default: st_d = S_EMPTY;
        endcase
        if (clr) st_d = S_EMPTY;
    end

    always_comb begin
        done   = (st_q == S_FULL);
        crc_ok = done && (crc_out == '0);
    end
endmodule

// File: rtl/onew_crc_chk.sv
module onew_crc_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr,
    input logic         bit_vld,
    input logic [W-1:0] crc_out,
    input logic         done,
    input logic         crc_ok
);
    // R7: clear zeroes register and frame state next cycle
    p_clr_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_out == '0) && !done);

    // R3: idle cycle keeps register
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld && !clr) |=> $stable(crc_out) && ($past(done) == done));

    // R6: full frame ignores further bits
    p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done && $stable(crc_out));

    // R5: pass flag only when done with zero residue
    p_ok_needs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok |-> done && (crc_out == '0));

    // R5: pass flag when full with zero residue
    p_ok_on_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && crc_out == '0) |-> crc_ok);
endmodule

bind onew_crc_top onew_crc_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .bit_vld (bit_vld),
    .crc_out (crc_out),
    .done    (done),
    .crc_ok  (crc_ok)
);

// File: tb/onew_crc_top_tb_top.sv
module onew_crc_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       bit_vld = 1'b0;
    logic       bit_in = 1'b0;
    logic [7:0] crc_out;
    logic       done;
    logic       crc_ok;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    onew_crc_top dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .bit_vld(bit_vld),
        .bit_in(bit_in), .crc_out(crc_out), .done(done), .crc_ok(crc_ok)
    );

    // {corrupt mask[63:56], payload[55:0]}
    localparam logic [63:0] VEC [4] = '{
        {8'h00, 56'h000000001CB802},
        {8'h00, 56'hFFFFFFFFFFFFFF},
        {8'h01, 56'h123456789ABC01},
        {8'h80, 56'hA5A5A5A5A5A5A5}
    };

    // Reference per R2: LSB-first, reflected 0x8C.
    function automatic logic [7:0] ref_crc(input logic [63:0] data, input int n);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < n; i++) begin
            if (c[0] ^ data[i]) c = (c >> 1) ^ 8'h8C;
            else                c = c >> 1;
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input int gap);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
        @(negedge clk);
        bit_vld = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_bits(input logic [63:0] d, input int lo, input int hi, input int gap);
        for (int i = lo; i < hi; i++) send_bit(d[i], gap);
    endtask

    task automatic do_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] fr;
        logic [7:0]  hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset crc", crc_out, 8'h00);
        chk("R1 reset done", done, 0);
        chk("R1 reset ok", crc_ok, 0);

        for (int v = 0; v < 4; v++) begin
            fr = {ref_crc({8'h00, VEC[v][55:0]}, 56) ^ VEC[v][63:56], VEC[v][55:0]};
            do_clr();
            send_bits(fr, 0, 56, v % 2);
            chk("R8 payload crc", crc_out, ref_crc(fr, 56));
            chk("R4 not done at 56", done, 0);
            send_bits(fr, 56, 64, 0);
            chk("R4 done at 64", done, 1);
            chk("R2 residue", crc_out, ref_crc(fr, 64));
            chk("R5 pass flag", crc_ok, (VEC[v][63:56] == 8'h00));
        end

        // R6: extra bits after full frame ignored
        hold = crc_out;
        send_bits(64'hFFFF, 0, 5, 0);
        chk("R6 crc hold", crc_out, hold);
        chk("R6 done hold", done, 1);

        // R4/R5: zero frame, 63 bits: zero register but not done
        do_clr();
        chk("R1 clear crc", crc_out, 8'h00);
        chk("R1 clear done", done, 0);
        send_bits(64'h0, 0, 63, 0);
        chk("R4 not done at 63", done, 0);
        chk("R5 no ok before done", crc_ok, 0);
        send_bit(1'b0, 0);
        chk("R5 ok zero frame", crc_ok, 1);

        // R3: idle gaps, no change
        do_clr();
        send_bits(64'h5, 0, 3, 0);
        hold = crc_out;
        repeat (4) @(negedge clk);
        chk("R3 idle hold", crc_out, hold);
        chk("R3 idle crc value", crc_out, ref_crc(64'h5, 3));

        // R7: clear with simultaneous bit
        send_bits(64'hFFFF, 0, 10, 0);
        @(negedge clk);
        clr = 1'b1; bit_vld = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        clr = 1'b0; bit_vld = 1'b0;
        chk("R7 clr priority crc", crc_out, 8'h00);
        chk("R7 clr priority done", done, 0);
        fr = {ref_crc({8'h00, 56'h000000001CB802}, 56), 56'h000000001CB802};
        send_bits(fr, 0, 64, 0);
        chk("R7 count restarted", done, 1);
        chk("R7 frame ok after clr", crc_ok, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule